// File: doc/BRIEF.md
# Edge-Triggered Inference Start Controller

This controller decides when a neural-network forward computation begins and reports when its result is ready. Two trigger levels reach it: one written over the register bus, one driven by neighbouring fabric logic. Each is turned into a rising-edge event by comparing it with its own value from the previous cycle. The two events are merged with a plain OR, so neither source has priority. A disable input can block the fabric source so that only the bus trigger can start work. Any edge that arrives while a computation is in flight is dropped and is not stored for later.

The controller sends a one-cycle start pulse to the arithmetic datapath. It then waits for the datapath's one-cycle done pulse. After that it raises a valid level and a one-cycle finished pulse in the same cycle. Valid stays high until the next accepted start.

The sequencer has three states:
- IDLE: after reset, no result yet.
- BUSY: a computation is running.
- HOLD: a result is held.

It has three transitions:
- launch (IDLE to BUSY)
- complete (BUSY to HOLD)
- relaunch (HOLD to BUSY)

Launch and relaunch need an accepted trigger edge. Complete needs the done pulse while in BUSY.

Top module: `start_ctl`

## Requirements
- R1: Asynchronous active-low reset puts the controller in IDLE with start, valid and finished low, and it clears the stored trigger history. This holds even if reset arrives while a result is held.
- R2: A computation starts only on a rising edge, meaning the trigger is 1 now and was 0 in the previous cycle. A trigger held at 1 for many cycles starts at most one computation.
- R3: A rising edge on either the bus trigger or the fabric trigger starts a computation. Simultaneous edges on both start exactly one.
- R4: While the fabric-disable input is 1, fabric rising edges are ignored and the bus trigger still works. A fabric trigger that rose while disabled does not start a computation when the disable is later cleared.
- R5: A rising edge that arrives while a computation runs is dropped. It causes no start pulse, either at that time or after the computation ends.
- R6: Valid is low in the cycle of the start pulse and for as long as the computation runs. It goes high in the cycle after the done pulse is sampled, and it stays high until the next accepted start.
- R7: Finished is high for exactly one cycle, the cycle after the done pulse is sampled in BUSY, and valid is high in that same cycle.
- R8: A rising edge sampled in the same cycle as the done pulse counts as arriving while busy and is dropped.
- R9: A done pulse sampled outside BUSY (in IDLE or HOLD) is ignored. It gives no finished pulse and no change of valid.
- R10: The start pulse is high for exactly one cycle. That cycle is the one after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_trig_i | input | 1 | Trigger level from the register bus |
| fab_trig_i | input | 1 | Trigger level from fabric logic |
| fab_dis_i | input | 1 | 1 blocks fabric trigger edges |
| calc_done_i | input | 1 | One-cycle completion pulse from the datapath |
| start_o | output | 1 | One-cycle start pulse to the datapath |
| valid_o | output | 1 | High while a completed result is held |
| finished_o | output | 1 | One-cycle pulse when a computation completes |

## Verification
Two functions of this block can fall in the same cycle.

The first pairing is completion and a new trigger edge. The bench raises the bus trigger in exactly the cycle in which it drives the done pulse. It then judges that valid and finished rise, that no start pulse appears, and that none appears later while the trigger stays high.

The second pairing is an edge on both trigger sources at once. The bench judges that this gives a single start pulse followed by silence.

// File: rtl/start_ctl_pkg.sv
package start_ctl_pkg;

    // Number of trigger sources; index 0 is the bus, index 1 is fabric
    localparam int N_SRC   = 2;
    localparam int SRC_BUS = 0;
    localparam int SRC_FAB = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sc_edge_detect.sv
module sc_edge_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= level_i[g];
            end
        end

        assign rise_o[g] = level_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/sc_trig_merge.sv
module sc_trig_merge #(
    parameter int W = 2
) (
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] block_i,
    output logic         launch_o
);

    logic [W-1:0] pass;

    // Blocked sources drop out; the survivors are ORed with no priority
    assign pass     = rise_i & ~block_i;
    assign launch_o = |pass;

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
    import start_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic done_i,
    output logic start_o,
    output logic valid_o,
    output logic finished_o
);

    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_i) state_d = ST_BUSY;   // launch
            ST_BUSY: if (done_i)   state_d = ST_HOLD;   // complete; edges dropped
            ST_HOLD: if (launch_i) state_d = ST_BUSY;   // relaunch
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o    <= 1'b0;
            valid_o    <= 1'b0;
            finished_o <= 1'b0;
        end else begin
            start_o    <= (state_q != ST_BUSY) && (state_d == ST_BUSY);
            finished_o <= (state_q == ST_BUSY) && (state_d == ST_HOLD);
            valid_o    <= (state_d == ST_HOLD);
        end
    end

endmodule

// File: rtl/start_ctl.sv
module start_ctl
    import start_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_trig_i,
    input  logic fab_trig_i,
    input  logic fab_dis_i,
    input  logic calc_done_i,
    output logic start_o,
    output logic valid_o,
    output logic finished_o
);

    logic [N_SRC-1:0] lvl;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] blk;
    logic             launch;

    always_comb begin
        lvl          = '0;
        blk          = '0;
        lvl[SRC_BUS] = bus_trig_i;
        lvl[SRC_FAB] = fab_trig_i;
        blk[SRC_FAB] = fab_dis_i;
    end

    sc_edge_detect #(.W(N_SRC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lvl),
        .rise_o  (rise)
    );

    sc_trig_merge #(.W(N_SRC)) u_merge (
        .rise_i   (rise),
        .block_i  (blk),
        .launch_o (launch)
    );

    sc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .done_i     (calc_done_i),
        .start_o    (start_o),
        .valid_o    (valid_o),
        .finished_o (finished_o)
    );

endmodule

// File: rtl/start_ctl_chk.sv
module start_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_trig_i,
    input logic fab_trig_i,
    input logic fab_dis_i,
    input logic calc_done_i,
    input logic start_o,
    input logic valid_o,
    input logic finished_o
);

    logic bus_q, fab_q, running_q;
    logic edge_now, busy_now;

    assign edge_now = (bus_trig_i & ~bus_q) | (fab_trig_i & ~fab_q & ~fab_dis_i);
    assign busy_now = start_o | running_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q     <= 1'b0;
            fab_q     <= 1'b0;
            running_q <= 1'b0;
        end else begin
            bus_q     <= bus_trig_i;
            fab_q     <= fab_trig_i;
            running_q <= busy_now & ~calc_done_i;
        end
    end

    // R10: start is a single-cycle pulse
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R2 and R4: every start follows an unmasked rising edge
    assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(edge_now));

    // R5: no start while a computation is outstanding
    assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> !start_o);

    // R6: valid stays low during a run
    assert_valid_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || running_q) |-> !valid_o);

    // R7: finished is one cycle and coincides with valid
    assert_finish_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |=> !finished_o);
    assert_finish_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> valid_o);

    // R9: finished only follows a done pulse taken during a run
    assert_done_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> $past(busy_now && calc_done_i));

endmodule

bind start_ctl start_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_trig_i  (bus_trig_i),
    .fab_trig_i  (fab_trig_i),
    .fab_dis_i   (fab_dis_i),
    .calc_done_i (calc_done_i),
    .start_o     (start_o),
    .valid_o     (valid_o),
    .finished_o  (finished_o)
);

// File: tb/sim_start_ctl.sv
`timescale 1ns/1ps
module sim_start_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_trig = 1'b0, fab_trig = 1'b0, fab_dis = 1'b0, done = 1'b0;
    logic start, valid, fin;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished_run = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    start_ctl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_trig_i  (bus_trig),
        .fab_trig_i  (fab_trig),
        .fab_dis_i   (fab_dis),
        .calc_done_i (done),
        .start_o     (start),
        .valid_o     (valid),
        .finished_o  (fin)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic b, f, d, dn;
        logic es, ev, ef;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R1 idle
        '{4'd3,  1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 bus start, R10
        '{4'd2,  1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R2 level held
        '{4'd5,  1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R5 fab edge while busy
        '{4'd7,  1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1}, // R7 completion
        '{4'd5,  1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R5 no late start
        '{4'd9,  1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0}, // R9 done in HOLD
        '{4'd3,  1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 fab start
        '{4'd6,  1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1}, // R6 valid rises
        '{4'd6,  1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0}, // R6 valid holds
        '{4'd4,  1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0}, // R4 masked fab edge
        '{4'd4,  1'b1,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R4 bus under mask
        '{4'd6,  1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R6 low while busy
        '{4'd8,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1}, // R8 edge with done
        '{4'd8,  1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R8 stays dropped
        '{4'd6,  1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R6
        '{4'd3,  1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 both edges
        '{4'd10, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R10 one pulse
        '{4'd7,  1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1}  // R7
    };

    task automatic check3(input string tag, input logic es, input logic ev, input logic ef);
        n_checks++;
        if (start !== es || valid !== ev || fin !== ef) begin
            n_fail++;
            $display("FAIL %s: start/valid/finished = %b%b%b expected %b%b%b",
                     tag, start, valid, fin, es, ev, ef);
        end
    endtask

    task automatic drive(input logic b, input logic f, input logic d, input logic dn);
        bus_trig = b; fab_trig = f; fab_dis = d; done = dn;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check3("R1 in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table: inputs at one negedge, outputs checked at the next
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].b, TBL[i].f, TBL[i].d, TBL[i].dn);
            @(negedge clk);
            check3($sformatf("R%0d row %0d", TBL[i].rq, i), TBL[i].es, TBL[i].ev, TBL[i].ef);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check3("R6 held result", 1'b0, 1'b1, 1'b0);

        // R1: reset while a result is held
        rst_n = 1'b0;
        #1 check3("R1 reset from HOLD", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: done in IDLE ignored
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check3("R9 done in IDLE", 1'b0, 1'b0, 1'b0);

        // R4: fab rose while disabled, then unmasked while high: no start
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check3("R4 masked rise", 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check3("R4 unmask no start", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check3("R4 still idle", 1'b0, 1'b0, 1'b0);

        // R2: fab falls and rises again: start from IDLE
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check3("R2 new rise starts", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check3("R10 pulse ends", 1'b0, 1'b0, 1'b0);

        finished_run = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule